// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block releases an I2C bus that a target device has left stuck with SDA held low. Software starts it by writing the control word with the recovery bit set. The block then clocks SCL one pulse at a time, using the phase strobes from the SCL clock generator. It samples SDA at the end of each high phase. When SDA is found high, no further pulses are sent. The block then drives a STOP condition so the bus ends idle, and sets a sticky completion flag in its status word.

If SDA is still low after the maximum number of pulses (eight by default), the sequence ends without a STOP. Failure then shows as a low SDA level in the status word, which software reads after the completion flag is set. The block only drives the two lines low through open-drain enables. It never drives SDA during the pulse train. A SCL held low by another device is only reported through the line status bit.

Top module: `i2c_bus_recovery`

## Requirements
- R1: After reset both line-drive enables are 0, the busy status bit (16) is 0 and the completion bit (13) is 0.
- R2: A sequence starts only on a control write (`cmd_we_i`=1) whose bit 11 is 1. A write with bit 11 at 0 causes no SCL activity.
- R3: When a sequence is accepted, SCL is driven low in the next cycle. Every later phase change waits for a `tick_i` strobe, and without strobes the line drives hold their values.
- R4: Each pulse is one low phase followed by one high phase. SDA is sampled at the strobe that ends the high phase. The sequence sends at least 1 and at most MAX_PULSES (8) pulses, and it stops after the first pulse whose sample reads SDA high.
- R5: SDA is never driven low before the last SCL pulse of the train has ended.
- R6: After SDA has been seen high, the block drives SCL low with SDA low, then releases SCL, then releases SDA while SCL is high (a STOP). After that the block is idle.
- R7: If SDA is still low at the end of pulse MAX_PULSES, the sequence ends with no STOP, and status bit 17 reads 0.
- R8: Completion sets status bit 13, on success and on failure alike. The bit stays set until `done_ack_i` is pulsed.
- R9: Status bit 17 shows the SDA line level, bit 18 shows the SCL line level, and bit 16 is 1 while a sequence is running.
- R10: A recovery write that arrives while a sequence is running is ignored. It does not extend the sequence or restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Control word write strobe |
| cmd_wdata_i | input | CMD_W (32) | Control word; bit 11 requests recovery |
| done_ack_i | input | 1 | Clears the completion flag |
| tick_i | input | 1 | SCL phase strobe from the clock generator |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_low_o | output | 1 | Drive SCL low (open-drain enable) |
| sda_low_o | output | 1 | Drive SDA low (open-drain enable) |
| status_o | output | STS_W (19) | Bit 13 completion, bit 16 busy, bit 17 SDA level, bit 18 SCL level |

## Verification
The bench uses the default MAX_PULSES of 8 and a 32-bit control word. With these values the full range of pulse counts can be reached: an SDA that is already free, releases at every count from one to eight, and a device that never lets go. The bench models the stuck device as one that frees SDA after a chosen number of SCL falling edges. It drives `tick_i` with random gaps, so each check depends on the strobes and not on cycle counts.

// File: rtl/i2c_rec_pkg.sv
package i2c_rec_pkg;
  typedef enum logic [2:0] {
    RS_IDLE,
    RS_LOW,
    RS_HIGH,
    RS_STP_LO,
    RS_STP_HI
  } rec_state_e;
endpackage

// File: rtl/i2c_rec_pulse_cnt.sv
module i2c_rec_pulse_cnt #(
  parameter int MAX_PULSES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(MAX_PULSES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(MAX_PULSES - 1));

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(MAX_PULSES));
endmodule

// File: rtl/i2c_rec_fsm.sv
module i2c_rec_fsm
  import i2c_rec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  input  logic sda_i,
  input  logic last_i,
  output logic cnt_clr_o,
  output logic cnt_inc_o,
  output logic scl_low_o,
  output logic sda_low_o,
  output logic busy_o,
  output logic finish_o
);
  rec_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    finish_o  = 1'b0;
    case (state_q)
      RS_IDLE: if (start_i) begin
        state_d   = RS_LOW;
        cnt_clr_o = 1'b1;
      end
      RS_LOW: if (tick_i) state_d = RS_HIGH;
      RS_HIGH: if (tick_i) begin
        if (sda_i) begin
          state_d = RS_STP_LO;
        end else if (last_i) begin
          state_d  = RS_IDLE;
          finish_o = 1'b1;
        end else begin
          state_d   = RS_LOW;
          cnt_inc_o = 1'b1;
        end
      end
      RS_STP_LO: if (tick_i) state_d = RS_STP_HI;
      RS_STP_HI: if (tick_i) begin
        state_d  = RS_IDLE;
        finish_o = 1'b1;
      end
      default: state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RS_IDLE;
    else         state_q <= state_d;
  end

  assign scl_low_o = (state_q == RS_LOW) || (state_q == RS_STP_LO);
  assign sda_low_o = (state_q == RS_STP_LO) || (state_q == RS_STP_HI);
  assign busy_o    = (state_q != RS_IDLE);

  assert_hold_no_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> ($stable(scl_low_o) && $stable(sda_low_o)));
  assert_fail_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RS_HIGH && tick_i && !sda_i && last_i) |=> (!busy_o && !sda_low_o));
  assert_stop_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_low_o) |-> !scl_low_o);
  assert_sda_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> $past(state_q == RS_HIGH && sda_i));
endmodule

// File: rtl/i2c_bus_recovery.sv
module i2c_bus_recovery #(
  parameter int CMD_W      = 32,
  parameter int REC_BIT    = 11,
  parameter int MAX_PULSES = 8,
  parameter int DONE_BIT   = 13,
  parameter int BUSY_BIT   = 16,
  parameter int SDA_BIT    = 17,
  parameter int SCL_BIT    = 18,
  parameter int STS_W      = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  input  logic             done_ack_i,
  input  logic             tick_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_low_o,
  output logic             sda_low_o,
  output logic [STS_W-1:0] status_o
);
  logic start, busy, finish, cnt_clr, cnt_inc, last, done_q;

  assign start = cmd_we_i && cmd_wdata_i[REC_BIT] && !busy;

  i2c_rec_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i   (start),
    .tick_i,
    .sda_i,
    .last_i    (last),
    .cnt_clr_o (cnt_clr),
    .cnt_inc_o (cnt_inc),
    .scl_low_o,
    .sda_low_o,
    .busy_o    (busy),
    .finish_o  (finish)
  );

  i2c_rec_pulse_cnt #(.MAX_PULSES(MAX_PULSES)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .last_o (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         done_q <= 1'b0;
    else if (finish)     done_q <= 1'b1;
    else if (done_ack_i) done_q <= 1'b0;
  end

  always_comb begin
    status_o           = '0;
    status_o[DONE_BIT] = done_q;
    status_o[BUSY_BIT] = busy;
    status_o[SDA_BIT]  = sda_i;
    status_o[SCL_BIT]  = scl_i;
  end

  assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !done_ack_i) |=> done_q);
  assert_busy_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cmd_we_i && !finish) |=> busy);
endmodule

// File: tb/test_i2c_bus_recovery.sv
module test_i2c_bus_recovery;
  logic        clk = 0, rst_n = 0;
  logic        cmd_we = 0, done_ack = 0, tick = 0, tick_en = 1;
  logic [31:0] cmd_wdata = '0;
  logic        scl_low, sda_low;
  logic [18:0] status;
  int          nrel = 0, falls = 0, rises = 0, stops = 0, first_sda = -1;
  int          n_chk = 0, n_err = 0, cyc = 0;
  logic        prev_scl = 1, prev_sda = 1, mon_clr = 0;
  wire         scl_line = ~scl_low;
  wire         sda_line = ~sda_low & (falls >= nrel);

  always #5 clk = ~clk;

  i2c_bus_recovery i_i2c_bus_recovery (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
    .done_ack_i(done_ack), .tick_i(tick), .scl_i(scl_line), .sda_i(sda_line),
    .scl_low_o(scl_low), .sda_low_o(sda_low), .status_o(status));

  always @(negedge clk) begin
    tick <= tick_en && ($urandom % 3 == 0);
    if (mon_clr) begin
      rises = 0; stops = 0; first_sda = -1;
    end else begin
      if (prev_scl && !scl_line) falls++;
      if (!prev_scl && scl_line) rises++;
      if (prev_scl && scl_line && !prev_sda && sda_line) stops++;
      if (sda_low && first_sda < 0) first_sda = rises;
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_pulses(input int n);
    if (n > 8) return 8;
    if (n < 1) return 1;
    return n;
  endfunction

  task automatic setup_slave(input int n);
    @(negedge clk);
    falls = 0; nrel = n; mon_clr = 1;
    @(negedge clk);
    mon_clr = 0;
  endtask

  task automatic write_cmd(input logic [31:0] d);
    @(negedge clk);
    cmd_we = 1; cmd_wdata = d;
    @(negedge clk);
    cmd_we = 0; cmd_wdata = '0;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 2000 && status[16]; i++) @(negedge clk);
  endtask

  task automatic trial(input int n, input bit dup);
    int ep; bit ok;
    ep = exp_pulses(n);
    ok = (n <= 8);
    setup_slave(n);
    write_cmd(32'h0000_0800);
    chk(status[16] == 1'b1, "R9 busy during run", status[16], 1);
    if (dup) begin
      repeat (3) @(negedge clk);
      write_cmd(32'hFFFF_FFFF);
    end
    wait_idle();
    repeat (2) @(negedge clk);
    chk(rises == ep + (ok ? 1 : 0), ok ? "R4 pulse count" : "R7 pulse count", rises, ep + (ok ? 1 : 0));
    chk(stops == (ok ? 1 : 0), ok ? "R6 stop issued" : "R7 no stop", stops, ok ? 1 : 0);
    if (ok) chk(first_sda == ep, "R5 sda quiet in train", first_sda, ep);
    else    chk(first_sda == -1, "R5 sda never driven", first_sda, -1);
    chk(status[17] == ok, "R7 sda status", status[17], ok);
    chk(status[18] == 1'b1, "R9 scl status", status[18], 1);
    chk(status[13] == 1'b1, "R8 done set", status[13], 1);
    repeat (5) @(negedge clk);
    chk(status[13] == 1'b1, "R8 done sticky", status[13], 1);
    done_ack = 1;
    @(negedge clk);
    done_ack = 0;
    @(negedge clk);
    chk(status[13] == 1'b0, "R8 done cleared", status[13], 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!scl_low && !sda_low, "R1 lines released", {scl_low, sda_low}, 0);
    chk(status[16] == 0 && status[13] == 0, "R1 status clear", status[16:13], 0);
    rst_n = 1;
    @(negedge clk);

    setup_slave(0);
    write_cmd(32'hFFFF_F7FF);
    repeat (20) @(negedge clk);
    chk(falls == 0 && status[16] == 0, "R2 write without bit 11", falls, 0);

    setup_slave(3);
    tick_en = 0;
    @(negedge clk);
    write_cmd(32'h0000_0800);
    chk(scl_low == 1, "R3 scl low after accept", scl_low, 1);
    repeat (20) @(negedge clk);
    chk(scl_low == 1 && status[18] == 0, "R3 hold without tick / R9 scl level", status[18], 0);
    tick_en = 1;
    wait_idle();
    repeat (2) @(negedge clk);
    chk(rises == 4, "R3 run after ticks resume", rises, 4);
    done_ack = 1; @(negedge clk); done_ack = 0;

    trial(0, 0);
    trial(1, 0);
    trial(8, 0);
    trial(9, 0);
    trial(12, 0);
    trial(5, 1);
    for (int k = 0; k < 8; k++) trial($urandom % 11, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule